// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a 4-bit synchronous counter that runs on a single system clock. It has no direction input. Instead it has two active-low count strobes: one that counts up and one that counts down. The block registers each strobe and finds its low-to-high transitions itself. Each valid transition moves the count by one step. A synchronous master reset clears the count, and an active-low load presets it from a 4-bit data input. Reset has priority over load, and load has priority over counting.

Two active-low terminal-count outputs let stages be chained. The carry output goes low while the count sits at its top value and the up strobe is low. The borrow output goes low while the count sits at zero and the down strobe is low. When a lower stage wraps, its carry or borrow rises, and that rise can serve as the next stage's count strobe. A parameter selects binary counting (modulo 16) or decade counting (modulo 10).

Top module: `dual_strobe_counter`

## Requirements
- R1: When `rst` is high at a clock edge, `q` becomes 0 after that edge, whatever `load_n`, `din`, `up_n` and `dn_n` are doing.
- R2: When `rst` is low and `load_n` is low at a clock edge, `q` takes the value of `din` after that edge, even if a strobe rises in the same cycle.
- R3: An up step happens at an edge where `up_n` is high and was low at the previous edge, while `dn_n` is high. The step adds one, and in binary mode 15 wraps to 0.
- R4: A down step happens at an edge where `dn_n` is high and was low at the previous edge, while `up_n` is high. The step subtracts one, and in binary mode 0 wraps to 15.
- R5: If a strobe rises while the other strobe is low, no step happens. If both strobes rise at the same edge, no step happens either.
- R6: `carry_n` is low exactly when `q` equals the top value (15 in binary, 9 in decade) and `up_n` is low. Otherwise it is high.
- R7: `borrow_n` is low exactly when `q` is 0 and `dn_n` is low. Otherwise it is high.
- R8: In decade mode, an up step from 9 or from any value above 9 gives 0. A down step from 0 gives 9, and a down step from any other value subtracts one.
- R9: If there is no reset, no load and no step at an edge, `q` keeps its value.
- R10: A second stage whose up strobe is the first stage's `carry_n`, and whose down strobe is the first stage's `borrow_n`, moves by one exactly when the first stage wraps in that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| load_n | input | 1 | Synchronous parallel preset, active low |
| din | input | 4 | Preset value |
| up_n | input | 1 | Count-up strobe, active low, steps on its rising edge |
| dn_n | input | 1 | Count-down strobe, active low, steps on its rising edge |
| q | output | 4 | Count value |
| carry_n | output | 1 | Terminal count up, active low |
| borrow_n | output | 1 | Terminal count down, active low |

## Verification
The embedded properties check the following on every cycle:
- the load copy,
- the wrap at the top value and at zero,
- holding of the count when no step is taken,
- that an up step and a down step are never granted together.

Some behaviour can only be shown by the directed scenarios:
- the reset value and the priority of reset over load,
- the reference run from 13 up through the wrap to 2 and back down to 13,
- rejection of conflicting strobes,
- the decade recovery from illegal presets,
- the level of each terminal-count output,
- a two-stage cascade advancing on the wrap of the lower stage.

// File: rtl/updn_pkg.sv
package updn_pkg;

    localparam int CNT_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        MODE_BIN = 1'b0,
        MODE_DEC = 1'b1
    } cmode_e;

    typedef struct packed {
        logic up;
        logic dn;
    } step_t;

    function automatic cnt_t top_val(cmode_e m);
        return (m == MODE_DEC) ? cnt_t'(9) : '1;
    endfunction

    function automatic cnt_t step_inc(cnt_t v, cmode_e m);
        if (v >= top_val(m)) return '0;
        return v + cnt_t'(1);
    endfunction

    function automatic cnt_t step_dec(cnt_t v, cmode_e m);
        if (v == '0) return top_val(m);
        return v - cnt_t'(1);
    endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
    input  logic clk,
    input  logic rst,
    input  logic strb_n,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= strb_n;
    end

    assign rise = strb_n & ~prev_q;

endmodule

// File: rtl/count_reg.sv
module count_reg
    import updn_pkg::*;
#(
    parameter cmode_e MODE = MODE_BIN
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load_n,
    input  cnt_t  din,
    input  step_t step,
    output cnt_t  q
);
    localparam cnt_t TOP = top_val(MODE);

    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst)           cnt_q <= '0;
        else if (!load_n)  cnt_q <= din;
        else if (step.up)  cnt_q <= step_inc(cnt_q, MODE);
        else if (step.dn)  cnt_q <= step_dec(cnt_q, MODE);
    end

    assign q = cnt_q;

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> cnt_q == $past(din));

    // R3
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && step.up && cnt_q == TOP) |=> cnt_q == '0);

    // R4
    dn_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && step.dn && cnt_q == '0) |=> cnt_q == TOP);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && !step.up && !step.dn) |=> $stable(cnt_q));

endmodule

// File: rtl/tc_gate.sv
module tc_gate
    import updn_pkg::*;
#(
    parameter cmode_e MODE = MODE_BIN
) (
    input  cnt_t q,
    input  logic up_n,
    input  logic dn_n,
    output logic carry_n,
    output logic borrow_n
);
    localparam cnt_t TOP = top_val(MODE);

    assign carry_n  = ~((q == TOP) & ~up_n);
    assign borrow_n = ~((q == '0) & ~dn_n);

endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter #(
    parameter updn_pkg::cmode_e MODE = updn_pkg::MODE_BIN
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load_n,
    input  logic [updn_pkg::CNT_W-1:0] din,
    input  logic                       up_n,
    input  logic                       dn_n,
    output logic [updn_pkg::CNT_W-1:0] q,
    output logic                       carry_n,
    output logic                       borrow_n
);
    import updn_pkg::*;

    localparam int NSTRB = 2;

    logic [NSTRB-1:0] strb_n;
    logic [NSTRB-1:0] rise;
    step_t            step;

    assign strb_n = {dn_n, up_n};

    for (genvar g = 0; g < NSTRB; g++) begin : g_edge
        strobe_edge u_edge (
            .clk    (clk),
            .rst    (rst),
            .strb_n (strb_n[g]),
            .rise   (rise[g])
        );
    end

    // a step needs the opposite strobe idle high and not rising together
    assign step.up = rise[0] & dn_n & ~rise[1];
    assign step.dn = rise[1] & up_n & ~rise[0];

    count_reg #(.MODE(MODE)) u_core (
        .clk    (clk),
        .rst    (rst),
        .load_n (load_n),
        .din    (din),
        .step   (step),
        .q      (q)
    );

    tc_gate #(.MODE(MODE)) u_tc (
        .q        (q),
        .up_n     (up_n),
        .dn_n     (dn_n),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    // R5
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !(step.up && step.dn));

endmodule

// File: tb/dual_strobe_counter_tb.sv
`timescale 1ns/1ps
module dual_strobe_counter_tb;
    import updn_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load_n = 1'b1;
    logic [3:0] din = 4'd0;
    logic up_n = 1'b1;
    logic dn_n = 1'b1;

    logic [3:0] q_b, q_d, q_h;
    logic cy_b, bw_b, cy_d, bw_d, cy_h, bw_h;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    int exp_b = 0;
    int exp_d = 0;
    int exp_h = 0;

    always #4 clk = ~clk;

    dual_strobe_counter #(.MODE(MODE_BIN)) u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .din(din),
        .up_n(up_n), .dn_n(dn_n), .q(q_b), .carry_n(cy_b), .borrow_n(bw_b));

    dual_strobe_counter #(.MODE(MODE_DEC)) u_dec (
        .clk(clk), .rst(rst), .load_n(load_n), .din(din),
        .up_n(up_n), .dn_n(dn_n), .q(q_d), .carry_n(cy_d), .borrow_n(bw_d));

    // upper cascade stage fed by the binary stage terminal counts
    dual_strobe_counter #(.MODE(MODE_BIN)) u_hi (
        .clk(clk), .rst(rst), .load_n(1'b1), .din(4'd0),
        .up_n(cy_b), .dn_n(bw_b), .q(q_h), .carry_n(cy_h), .borrow_n(bw_h));

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int m_up(int v, int top);
        return (v >= top) ? 0 : v + 1;
    endfunction

    function automatic int m_dn(int v, int top);
        return (v == 0) ? top : v - 1;
    endfunction

    task automatic check_both(string req);
        chk({req, " bin q"}, q_b, exp_b);
        chk({req, " dec q"}, q_d, exp_d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; load_n = 1'b0; din = 4'd7; up_n = 1'b1; dn_n = 1'b1;
        @(negedge clk);
        rst = 1'b0; load_n = 1'b1;
        exp_b = 0; exp_d = 0; exp_h = 0;
        check_both("R1 reset");
        chk("R1 reset hi q", q_h, 0);
    endtask

    task automatic do_load(int v);
        @(negedge clk);
        load_n = 1'b0; din = 4'(v);
        @(negedge clk);
        load_n = 1'b1;
        exp_b = v; exp_d = v;
        check_both("R2 load");
    endtask

    task automatic pulse_up();
        @(negedge clk);
        up_n = 1'b0;
        @(negedge clk);
        chk("R6 carry bin", cy_b, (exp_b == 15) ? 0 : 1);
        chk("R6 carry dec", cy_d, (exp_d == 9) ? 0 : 1);
        up_n = 1'b1;
        @(negedge clk);
        exp_b = m_up(exp_b, 15);
        exp_d = m_up(exp_d, 9);
        check_both("R3 R8 up step");
        chk("R6 carry idle", cy_b, 1);
    endtask

    task automatic pulse_dn();
        @(negedge clk);
        dn_n = 1'b0;
        @(negedge clk);
        chk("R7 borrow bin", bw_b, (exp_b == 0) ? 0 : 1);
        chk("R7 borrow dec", bw_d, (exp_d == 0) ? 0 : 1);
        dn_n = 1'b1;
        @(negedge clk);
        exp_b = m_dn(exp_b, 15);
        exp_d = m_dn(exp_d, 9);
        check_both("R4 R8 down step");
        chk("R7 borrow idle", bw_b, 1);
    endtask

    task automatic t_reference();
        do_reset();
        do_load(13);
        for (int i = 0; i < 5; i++) pulse_up();
        chk("R3 ref reach 2", q_b, 2);
        for (int i = 0; i < 5; i++) pulse_dn();
        chk("R4 ref back 13", q_b, 13);
    endtask

    task automatic t_priority();
        do_reset();
        do_load(6);
        // reset beats load and a rising strobe
        @(negedge clk);
        up_n = 1'b0;
        @(negedge clk);
        up_n = 1'b1; rst = 1'b1; load_n = 1'b0; din = 4'd11;
        @(negedge clk);
        rst = 1'b0; load_n = 1'b1;
        exp_b = 0; exp_d = 0;
        check_both("R1 reset over load");
        // load beats a rising strobe
        @(negedge clk);
        up_n = 1'b0;
        @(negedge clk);
        up_n = 1'b1; load_n = 1'b0; din = 4'd5;
        @(negedge clk);
        load_n = 1'b1;
        exp_b = 5; exp_d = 5;
        check_both("R2 load over count");
        // idle cycles keep the value
        repeat (3) @(negedge clk);
        check_both("R9 hold idle");
    endtask

    task automatic t_conflict();
        do_reset();
        do_load(4);
        @(negedge clk);
        up_n = 1'b0; dn_n = 1'b0;
        @(negedge clk);
        up_n = 1'b1;
        @(negedge clk);
        check_both("R5 up while down low");
        up_n = 1'b0;
        @(negedge clk);
        up_n = 1'b1; dn_n = 1'b1;
        @(negedge clk);
        check_both("R5 both rise");
        @(negedge clk);
        check_both("R5 after both rise");
    endtask

    task automatic t_decade();
        do_reset();
        do_load(8);
        pulse_up();
        chk("R8 dec 9", q_d, 9);
        pulse_up();
        chk("R8 dec wrap up", q_d, 0);
        pulse_dn();
        chk("R8 dec wrap down", q_d, 9);
        do_load(12);
        pulse_up();
        chk("R8 dec above 9 up", q_d, 0);
        chk("R3 bin 12 up", q_b, 13);
        do_load(11);
        pulse_dn();
        chk("R8 dec above 9 down", q_d, 10);
    endtask

    task automatic t_cascade();
        do_reset();
        for (int i = 0; i < 20; i++) pulse_up();
        chk("R10 cascade hi up", q_h, 1);
        chk("R10 cascade lo up", q_b, 4);
        for (int i = 0; i < 5; i++) pulse_dn();
        chk("R10 cascade hi down", q_h, 0);
        chk("R10 cascade lo down", q_b, 15);
        pulse_up();
        chk("R10 cascade hi again", q_h, 1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reference();
        t_priority();
        t_conflict();
        t_decade();
        t_cascade();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule